// File: doc/BRIEF.md
# Coalescing Store Buffer with Fence Drain

This block sits between a core's store path and a cache write port. It holds a small set of entries, each one cache block wide, and gathers byte-masked stores into them. A store whose block already has an open entry is folded into that entry, even when stores to other blocks were accepted in between. Entries leave through the write port in slot order rather than arrival order. This reordering is safe only because fence boundaries are enforced: a fence request seals every live entry, blocks new stores, and is acknowledged only after all sealed entries have been written.

Two state machines control the block. The drain machine has the states DRN_IDLE and DRN_SEND. In DRN_IDLE, when an entry is eligible, it takes that entry into an output register, frees the slot and moves to DRN_SEND (transition "take"). In DRN_SEND it presents the write and returns to DRN_IDLE when the port accepts it (transition "accept"). The fence machine has the states FNC_OPEN, FNC_FLUSH and FNC_DONE. FNC_OPEN moves to FNC_FLUSH when a fence request is seen, sealing all live entries in that cycle ("seal"). FNC_FLUSH moves to FNC_DONE once no entry is live and no write is in flight ("drained"). FNC_DONE holds the acknowledge and returns to FNC_OPEN when the request is withdrawn ("release").

The drain policy maximises merging. Unsealed entries are drained only when every slot is occupied. Sealed entries are drained as soon as the write port is free.

Top module: `coalesce_store_buffer`

## Requirements
- R1: While reset is asserted and after it is released, wr_valid and fence_ack are low and every slot is empty, so st_ready is high when no fence is requested.
- R2: A store that hits an open (unsealed) entry with the same block address overwrites only the bytes whose st_mask bit is set, and ORs its mask into the entry mask. At most one open entry exists per block address.
- R3: Merging into an open entry happens even when stores to other blocks were accepted between the two stores.
- R4: A store to a block with no open entry takes the lowest-numbered free slot. Bytes that no store enabled are written out as zero.
- R5: A store that needs a new slot while all slots are occupied sees st_ready low until a slot is freed. A store that hits an open entry is accepted even when all slots are occupied.
- R6: In DRN_IDLE, the lowest-numbered sealed entry is taken if any entry is sealed. Otherwise the lowest-numbered eligible entry is taken, but only when all slots are occupied. The write appears the cycle after the take. wr_blk_addr, wr_data and wr_mask stay stable until wr_ready, and the slot is free from the cycle after the take.
- R7: When fence_req is sampled high in FNC_OPEN, every occupied entry becomes sealed. st_ready is low whenever fence_req is high or the fence machine is not in FNC_OPEN.
- R8: fence_ack goes high only when no entry is occupied and no write is pending. It stays high while fence_req is high and drops the cycle after fence_req falls.
- R9: A sealed entry accepts no merge. A store to a block issued after a fence produces a write separate from the same block's pre-fence data.
- R10: If a store merges into an entry in the same cycle that the drain machine would otherwise take that entry, the drain takes the next eligible slot instead, so the merged bytes are not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered by the core |
| st_ready | output | 1 | Store accepted this cycle when high together with st_valid |
| st_blk_addr | input | ADDR_W | Block address of the store |
| st_data | input | BLK_BYTES*8 | Store data, byte b in bits 8b+7..8b |
| st_mask | input | BLK_BYTES | Byte enables, bit b enables byte b |
| fence_req | input | 1 | Fence request, held until fence_ack, then dropped |
| fence_ack | output | 1 | Fence complete, held until fence_req drops |
| wr_valid | output | 1 | Block write to the cache is pending |
| wr_ready | input | 1 | Cache accepts the pending write |
| wr_blk_addr | output | ADDR_W | Block address of the write |
| wr_data | output | BLK_BYTES*8 | Block data of the write |
| wr_mask | output | BLK_BYTES | Valid-byte mask of the write |

## Verification
The hardest case to reach is R10: the merge and the drain take must target the same slot in the same cycle. This needs all slots occupied, the drain machine idle, and a hitting store presented in the very cycle after the fourth allocation. The stimulus empties the buffer with a fence, then issues four distinct-block stores back to back and follows them at once with a second store to the first block. A behavioural reference model compares every port on every clock. Directed checks on the write log confirm out-of-order draining, fence separation, and the full-buffer stall while the write port is held back.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic {
        DRN_IDLE,
        DRN_SEND
    } drn_state_e;

    typedef enum logic [1:0] {
        FNC_OPEN,
        FNC_FLUSH,
        FNC_DONE
    } fnc_state_e;

endpackage

// File: rtl/sb_lookup.sv
module sb_lookup #(
    parameter int NUM_ENT = 4,
    parameter int ADDR_W  = 28,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic [NUM_ENT-1:0]             ent_valid,
    input  logic [NUM_ENT-1:0]             ent_sealed,
    input  logic [NUM_ENT-1:0][ADDR_W-1:0] ent_addr,
    input  logic [ADDR_W-1:0]              st_addr,
    input  logic                           st_fire,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx,
    output logic                           free_any,
    output logic [IDX_W-1:0]               free_idx,
    output logic                           pick_any,
    output logic [IDX_W-1:0]               pick_idx
);

    logic [NUM_ENT-1:0] open_match;
    logic [NUM_ENT-1:0] drain_ok;
    logic [NUM_ENT-1:0] sealed_live;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
        assign open_match[g]  = ent_valid[g] & ~ent_sealed[g] & (ent_addr[g] == st_addr);
        assign drain_ok[g]    = ent_valid[g] & ~(st_fire & open_match[g]);
        assign sealed_live[g] = ent_valid[g] & ent_sealed[g];
    end

    // lowest-index open match
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (open_match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    // lowest-index free slot
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // drain candidate: sealed first, otherwise only when every slot is occupied
    always_comb begin
        pick_any = 1'b0;
        pick_idx = '0;
        if (|sealed_live) begin
            for (int i = NUM_ENT - 1; i >= 0; i--) begin
                if (sealed_live[i]) begin
                    pick_any = 1'b1;
                    pick_idx = IDX_W'(i);
                end
            end
        end else if (&ent_valid) begin
            for (int i = NUM_ENT - 1; i >= 0; i--) begin
                if (drain_ok[i]) begin
                    pick_any = 1'b1;
                    pick_idx = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/sb_drain_ctrl.sv
module sb_drain_ctrl
    import sb_pkg::*;
#(
    parameter int ADDR_W    = 28,
    parameter int BLK_BYTES = 16,
    localparam int DATA_W   = BLK_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pick_any,
    input  logic [ADDR_W-1:0]    pick_addr,
    input  logic [DATA_W-1:0]    pick_data,
    input  logic [BLK_BYTES-1:0] pick_mask,
    input  logic                 wr_ready,
    output logic                 take,
    output logic                 busy,
    output logic                 wr_valid,
    output logic [ADDR_W-1:0]    wr_blk_addr,
    output logic [DATA_W-1:0]    wr_data,
    output logic [BLK_BYTES-1:0] wr_mask
);

    drn_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DRN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DRN_IDLE: if (pick_any) state_d = DRN_SEND;
            DRN_SEND: if (wr_ready) state_d = DRN_IDLE;
            default:  state_d = DRN_IDLE;
        endcase
    end

    always_comb begin
        take     = (state_q == DRN_IDLE) && pick_any;
        busy     = (state_q == DRN_SEND);
        wr_valid = (state_q == DRN_SEND);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_blk_addr <= '0;
            wr_data     <= '0;
            wr_mask     <= '0;
        end else if (take) begin
            wr_blk_addr <= pick_addr;
            wr_data     <= pick_data;
            wr_mask     <= pick_mask;
        end
    end

endmodule

// File: rtl/sb_fence_ctrl.sv
module sb_fence_ctrl
    import sb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fence_req,
    input  logic buf_empty,
    input  logic drain_busy,
    output logic seal_all,
    output logic fence_ack,
    output logic accept_ok
);

    fnc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FNC_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FNC_OPEN:  if (fence_req)                state_d = FNC_FLUSH;
            FNC_FLUSH: if (buf_empty && !drain_busy) state_d = FNC_DONE;
            FNC_DONE:  if (!fence_req)               state_d = FNC_OPEN;
            default:                                 state_d = FNC_OPEN;
        endcase
    end

    always_comb begin
        seal_all  = (state_q == FNC_OPEN) && fence_req;
        fence_ack = (state_q == FNC_DONE);
        accept_ok = (state_q == FNC_OPEN) && !fence_req;
    end

endmodule

// File: rtl/coalesce_store_buffer.sv
module coalesce_store_buffer #(
    parameter int NUM_ENT   = 4,
    parameter int ADDR_W    = 28,
    parameter int BLK_BYTES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   st_valid,
    output logic                   st_ready,
    input  logic [ADDR_W-1:0]      st_blk_addr,
    input  logic [BLK_BYTES*8-1:0] st_data,
    input  logic [BLK_BYTES-1:0]   st_mask,
    input  logic                   fence_req,
    output logic                   fence_ack,
    output logic                   wr_valid,
    input  logic                   wr_ready,
    output logic [ADDR_W-1:0]      wr_blk_addr,
    output logic [BLK_BYTES*8-1:0] wr_data,
    output logic [BLK_BYTES-1:0]   wr_mask
);

    localparam int DATA_W = BLK_BYTES * 8;
    localparam int IDX_W  = $clog2(NUM_ENT);

    logic [NUM_ENT-1:0]                ent_valid;
    logic [NUM_ENT-1:0]                ent_sealed;
    logic [NUM_ENT-1:0][ADDR_W-1:0]    ent_addr;
    logic [NUM_ENT-1:0][DATA_W-1:0]    ent_data;
    logic [NUM_ENT-1:0][BLK_BYTES-1:0] ent_mask;

    logic             hit, free_any, pick_any;
    logic [IDX_W-1:0] hit_idx, free_idx, pick_idx;
    logic             take, drain_busy, seal_all, accept_ok, st_fire;
    logic [DATA_W-1:0] merge_data, fresh_data;

    assign st_ready = accept_ok & (hit | free_any);
    assign st_fire  = st_valid & st_ready;

    sb_lookup #(
        .NUM_ENT (NUM_ENT),
        .ADDR_W  (ADDR_W)
    ) u_lookup (
        .ent_valid  (ent_valid),
        .ent_sealed (ent_sealed),
        .ent_addr   (ent_addr),
        .st_addr    (st_blk_addr),
        .st_fire    (st_fire),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .free_any   (free_any),
        .free_idx   (free_idx),
        .pick_any   (pick_any),
        .pick_idx   (pick_idx)
    );

    sb_drain_ctrl #(
        .ADDR_W    (ADDR_W),
        .BLK_BYTES (BLK_BYTES)
    ) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .pick_any    (pick_any),
        .pick_addr   (ent_addr[pick_idx]),
        .pick_data   (ent_data[pick_idx]),
        .pick_mask   (ent_mask[pick_idx]),
        .wr_ready    (wr_ready),
        .take        (take),
        .busy        (drain_busy),
        .wr_valid    (wr_valid),
        .wr_blk_addr (wr_blk_addr),
        .wr_data     (wr_data),
        .wr_mask     (wr_mask)
    );

    sb_fence_ctrl u_fence (
        .clk        (clk),
        .rst_n      (rst_n),
        .fence_req  (fence_req),
        .buf_empty  (~|ent_valid),
        .drain_busy (drain_busy),
        .seal_all   (seal_all),
        .fence_ack  (fence_ack),
        .accept_ok  (accept_ok)
    );

    // byte lanes: a new entry keeps only enabled bytes, a merge overlays them
    for (genvar b = 0; b < BLK_BYTES; b++) begin : g_lane
        assign fresh_data[b*8 +: 8] = st_mask[b] ? st_data[b*8 +: 8] : 8'h00;
        assign merge_data[b*8 +: 8] = st_mask[b] ? st_data[b*8 +: 8]
                                                 : ent_data[hit_idx][b*8 +: 8];
    end

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
        logic                 v_q, s_q;
        logic [ADDR_W-1:0]    a_q;
        logic [DATA_W-1:0]    d_q;
        logic [BLK_BYTES-1:0] m_q;
        logic                 is_pick, is_hit, is_alloc;

        assign is_pick  = take && (pick_idx == IDX_W'(g));
        assign is_hit   = st_fire && hit && (hit_idx == IDX_W'(g));
        assign is_alloc = st_fire && !hit && (free_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                s_q <= 1'b0;
                a_q <= '0;
                d_q <= '0;
                m_q <= '0;
            end else if (is_pick) begin
                v_q <= 1'b0;
                s_q <= 1'b0;
            end else begin
                if (seal_all && v_q) s_q <= 1'b1;
                if (is_hit) begin
                    d_q <= merge_data;
                    m_q <= m_q | st_mask;
                end else if (is_alloc) begin
                    v_q <= 1'b1;
                    s_q <= 1'b0;
                    a_q <= st_blk_addr;
                    d_q <= fresh_data;
                    m_q <= st_mask;
                end
            end
        end

        assign ent_valid[g]  = v_q;
        assign ent_sealed[g] = s_q;
        assign ent_addr[g]   = a_q;
        assign ent_data[g]   = d_q;
        assign ent_mask[g]   = m_q;
    end

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NUM_ENT   = 4,
    parameter int ADDR_W    = 28,
    parameter int BLK_BYTES = 16
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                st_valid,
    input logic                                st_ready,
    input logic                                hit,
    input logic                                fence_req,
    input logic                                fence_ack,
    input logic                                wr_valid,
    input logic                                wr_ready,
    input logic [ADDR_W-1:0]                   wr_blk_addr,
    input logic [BLK_BYTES*8-1:0]              wr_data,
    input logic [BLK_BYTES-1:0]                wr_mask,
    input logic [NUM_ENT-1:0]                  ent_valid,
    input logic [NUM_ENT-1:0]                  ent_sealed,
    input logic [NUM_ENT-1:0][ADDR_W-1:0]      ent_addr,
    input logic [NUM_ENT-1:0][BLK_BYTES-1:0]   ent_mask
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!wr_valid && !fence_ack));

    p_full_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && (&ent_valid) && !hit) |-> !st_ready);

    p_payload_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_blk_addr)
                                     && $stable(wr_data) && $stable(wr_mask)));

    p_fence_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fence_req |-> !st_ready);

    p_ack_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_ack && fence_req) |=> fence_ack);

    p_ack_drained_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fence_ack) |-> (!wr_valid && !(|ent_valid)));

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_i
        p_sealed_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_valid[i] && ent_sealed[i]) |=>
                (!ent_valid[i] || (ent_sealed[i] && $stable(ent_mask[i]))));
        for (genvar j = i + 1; j < NUM_ENT; j++) begin : g_j
            p_one_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !(ent_valid[i] && !ent_sealed[i] && ent_valid[j] && !ent_sealed[j]
                  && (ent_addr[i] == ent_addr[j])));
        end
    end

endmodule

bind coalesce_store_buffer sb_checker #(
    .NUM_ENT   (NUM_ENT),
    .ADDR_W    (ADDR_W),
    .BLK_BYTES (BLK_BYTES)
) u_sb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_valid    (st_valid),
    .st_ready    (st_ready),
    .hit         (hit),
    .fence_req   (fence_req),
    .fence_ack   (fence_ack),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_blk_addr (wr_blk_addr),
    .wr_data     (wr_data),
    .wr_mask     (wr_mask),
    .ent_valid   (ent_valid),
    .ent_sealed  (ent_sealed),
    .ent_addr    (ent_addr),
    .ent_mask    (ent_mask)
);

// File: tb/tb_coalesce_store_buffer.sv
module tb_coalesce_store_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;
    localparam int AW = 28;
    localparam int BB = 16;
    localparam int DW = BB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [AW-1:0] st_blk_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [BB-1:0] st_mask = '0;
    logic          fence_req = 1'b0;
    logic          fence_ack;
    logic          wr_valid;
    logic          wr_ready = 1'b0;
    logic [AW-1:0] wr_blk_addr;
    logic [DW-1:0] wr_data;
    logic [BB-1:0] wr_mask;

    coalesce_store_buffer #(.NUM_ENT(NE), .ADDR_W(AW), .BLK_BYTES(BB)) dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_blk_addr(st_blk_addr),
        .st_data(st_data), .st_mask(st_mask),
        .fence_req(fence_req), .fence_ack(fence_ack),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_blk_addr(wr_blk_addr),
        .wr_data(wr_data), .wr_mask(wr_mask)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int release_cyc = 0;
    bit last_acc, last_ack;

    // behavioural reference state
    bit            m_v [NE];
    bit            m_s [NE];
    logic [AW-1:0] m_a [NE];
    logic [DW-1:0] m_d [NE];
    logic [BB-1:0] m_m [NE];
    int            m_dst = 0;
    int            m_fst = 0;
    int            m_allocs = 0;
    logic [AW-1:0] mo_a = '0;
    logic [DW-1:0] mo_d = '0;
    logic [BB-1:0] mo_m = '0;

    logic [AW-1:0] log_a [$];
    logic [DW-1:0] log_d [$];
    logic [BB-1:0] log_m [$];

    task automatic check(input bit ok, input string tag,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    task automatic tick();
        bit hit, fok, rdy, fire, anys, full, emp;
        int hidx, fidx, pidx;
        wr_ready = (rdy_mode == 0) || (rdy_mode == 1 && (cyc % 2 == 0))
                   || (rdy_mode == 3 && cyc >= release_cyc);
        #1;
        hit = 0; fok = 0; hidx = 0; fidx = 0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (m_v[i] && !m_s[i] && m_a[i] == st_blk_addr) begin hit = 1; hidx = i; end
            if (!m_v[i]) begin fok = 1; fidx = i; end
        end
        rdy  = !fence_req && (m_fst == 0) && (hit || fok);
        fire = st_valid && rdy;
        check(st_ready === rdy, "R5 st_ready", DW'(st_ready), DW'(rdy));
        check(wr_valid === (m_dst == 1), "R6 wr_valid", DW'(wr_valid), DW'(m_dst == 1));
        if (m_dst == 1) begin
            check(wr_blk_addr === mo_a, "R2 wr_blk_addr", DW'(wr_blk_addr), DW'(mo_a));
            check(wr_mask === mo_m, "R2 wr_mask", DW'(wr_mask), DW'(mo_m));
            check(wr_data === mo_d, "R4 wr_data", wr_data, mo_d);
        end
        check(fence_ack === (m_fst == 2), "R8 fence_ack", DW'(fence_ack), DW'(m_fst == 2));
        last_acc = st_valid && st_ready;
        last_ack = fence_ack;
        if (wr_valid && wr_ready) begin
            log_a.push_back(wr_blk_addr);
            log_d.push_back(wr_data);
            log_m.push_back(wr_mask);
        end
        anys = 0; full = 1; emp = 1; pidx = -1;
        for (int i = 0; i < NE; i++) begin
            if (m_v[i] && m_s[i]) anys = 1;
            if (!m_v[i]) full = 0; else emp = 0;
        end
        if (m_dst == 0) begin
            if (anys) begin
                for (int i = NE - 1; i >= 0; i--) if (m_v[i] && m_s[i]) pidx = i;
            end else if (full) begin
                for (int i = NE - 1; i >= 0; i--)
                    if (m_v[i] && !(fire && hit && hidx == i)) pidx = i;
            end
        end
        @(posedge clk);
        case (m_fst)
            0: if (fence_req) begin
                   for (int i = 0; i < NE; i++) if (m_v[i]) m_s[i] = 1;
                   m_fst = 1;
               end
            1: if (emp && m_dst == 0) m_fst = 2;
            default: if (!fence_req) m_fst = 0;
        endcase
        if (m_dst == 1 && wr_ready) m_dst = 0;
        if (pidx >= 0) begin
            mo_a = m_a[pidx]; mo_d = m_d[pidx]; mo_m = m_m[pidx];
            m_v[pidx] = 0; m_s[pidx] = 0; m_dst = 1;
        end
        if (fire) begin
            if (hit) begin
                for (int b = 0; b < BB; b++)
                    if (st_mask[b]) m_d[hidx][b*8 +: 8] = st_data[b*8 +: 8];
                m_m[hidx] = m_m[hidx] | st_mask;
            end else begin
                m_v[fidx] = 1; m_s[fidx] = 0; m_a[fidx] = st_blk_addr; m_m[fidx] = st_mask;
                for (int b = 0; b < BB; b++)
                    m_d[fidx][b*8 +: 8] = st_mask[b] ? st_data[b*8 +: 8] : 8'h00;
                m_allocs++;
            end
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic do_store(input logic [AW-1:0] a, input logic [7:0] pat,
                            input logic [BB-1:0] m, output int waited);
        st_valid = 1; st_blk_addr = a; st_data = {BB{pat}}; st_mask = m;
        waited = 0;
        do begin
            tick();
            waited++;
        end while (!last_acc && waited < 100);
        st_valid = 0;
    endtask

    task automatic do_fence(input bit offer, output int accepted);
        int g;
        accepted = 0; g = 0;
        fence_req = 1;
        if (offer) begin
            st_valid = 1; st_blk_addr = 28'h9999; st_data = {BB{8'h99}}; st_mask = '1;
        end
        do begin
            tick();
            if (last_acc) accepted++;
            g++;
        end while (!last_ack && g < 100);
        st_valid = 0;
        check(log_a.size() == m_allocs, "R8 all earlier stores written at ack",
              DW'(log_a.size()), DW'(m_allocs));
        fence_req = 0;
        tick();
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int w, acc, base;
        for (int i = 0; i < NE; i++) begin
            m_v[i] = 0; m_s[i] = 0; m_a[i] = '0; m_d[i] = '0; m_m[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check(st_ready === 1'b1, "R1 st_ready after reset", DW'(st_ready), 1);
        check(wr_valid === 1'b0, "R1 wr_valid after reset", DW'(wr_valid), 0);
        check(fence_ack === 1'b0, "R1 fence_ack after reset", DW'(fence_ack), 0);
        @(negedge clk);

        // merge across an intervening store, then fill to trigger a drain
        rdy_mode = 0;
        do_store(28'h100, 8'hA1, 16'h000F, w);
        do_store(28'h200, 8'hB1, 16'hFFFF, w);
        do_store(28'h100, 8'hA2, 16'h00F0, w);
        do_store(28'h300, 8'hC1, 16'hFFFF, w);
        do_store(28'h400, 8'hD1, 16'hFFFF, w);
        repeat (4) tick();
        check(log_a.size() == 1, "R6 one drain once full", DW'(log_a.size()), 1);
        check(log_a[0] == 28'h100, "R3 merged block address", DW'(log_a[0]), 28'h100);
        check(log_m[0] == 16'h00FF, "R3 merged mask", DW'(log_m[0]), 16'h00FF);
        check(log_d[0] == 128'hA2A2A2A2A1A1A1A1, "R4 merged data with zero bytes",
              log_d[0], 128'hA2A2A2A2A1A1A1A1);

        // new block reuses slot 0 and drains ahead of older entries
        do_store(28'h500, 8'hE1, 16'h0001, w);
        repeat (4) tick();
        check(log_a[1] == 28'h500, "R6 out-of-order drain by slot", DW'(log_a[1]), 28'h500);

        // full buffer with the write port held off
        rdy_mode = 3; release_cyc = cyc + 12;
        do_store(28'h600, 8'hF1, 16'h00FF, w);
        do_store(28'h700, 8'h71, 16'h00FF, w);
        do_store(28'h800, 8'h81, 16'h00FF, w);
        check(w > 3, "R5 stall while full", DW'(w), 4);
        do_store(28'h300, 8'hC2, 16'hF000, w);
        check(w == 1, "R5 hit accepted while full", DW'(w), 1);
        rdy_mode = 1;
        do_fence(1'b1, acc);
        check(acc == 0, "R7 no store accepted during fence", DW'(acc), 0);

        // same block before and after a fence
        do_store(28'hA00, 8'h11, 16'h000F, w);
        do_fence(1'b0, acc);
        do_store(28'hA00, 8'h22, 16'hF000, w);
        do_fence(1'b0, acc);
        check(log_a[log_a.size()-2] == 28'hA00 && log_m[log_a.size()-2] == 16'h000F,
              "R9 pre-fence write separate", DW'(log_m[log_a.size()-2]), 16'h000F);
        check(log_a[log_a.size()-1] == 28'hA00 && log_m[log_a.size()-1] == 16'hF000,
              "R9 post-fence write separate", DW'(log_m[log_a.size()-1]), 16'hF000);

        // merge into the slot the drain would take in the same cycle
        rdy_mode = 0;
        base = log_a.size();
        do_store(28'hB00, 8'h31, 16'h000F, w);
        do_store(28'hB10, 8'h32, 16'hFFFF, w);
        do_store(28'hB20, 8'h33, 16'hFFFF, w);
        do_store(28'hB30, 8'h34, 16'hFFFF, w);
        do_store(28'hB00, 8'h35, 16'h00F0, w);
        repeat (3) tick();
        do_fence(1'b0, acc);
        check(log_a[base] == 28'hB10, "R10 drain skips merging slot", DW'(log_a[base]), 28'hB10);
        check(log_a[base+1] == 28'hB00, "R6 sealed lowest slot first", DW'(log_a[base+1]), 28'hB00);
        check(log_m[base+1] == 16'h00FF, "R10 merged bytes kept", DW'(log_m[base+1]), 16'h00FF);
        check(log_a.size() == base + 4, "R8 every entry written", DW'(log_a.size()), DW'(base + 4));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule